// File: doc/BRIEF.md
# FIFO Threshold Interrupt and Error Status Logic

This block sits beside the transmit and receive FIFOs of a serial peripheral and turns their occupancy counts into three interrupt lines and a 32-bit status word. The FIFO storage and the register decoder live elsewhere. The decoder hands this block its control fields: the two interrupt mode selects, the word width, the fault enables and the clear strobes. The FIFOs hand it their registered fill counts.

The receive and transmit interrupts are level signals. Each one follows one of four conditions on its FIFO, chosen by a 2-bit mode field. The buffer has a fixed size in bytes, so the FIFO depth in entries depends on the word width in use. Three error conditions are recorded as sticky flags:

- receive overflow, which also drops the incoming word;
- transmit underrun while framing is on;
- a duplicate frame-sync pulse.

Each flag stays set until software clears it. The fault interrupt is raised by any flag whose enable bit is set.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: With the default 16-byte buffer, the FIFO depth is 16 entries when `width_sel` is 0 (8-bit words), 8 entries when it is 1 (16-bit), and 4 entries when it is 2 or 3 (32-bit).
- R2: `rx_irq` follows `rx_mode`: 0 asserts it when `rx_level` is 0; 1 asserts it when `rx_level` is nonzero; 2 asserts it when `rx_level` is at least half the depth; 3 asserts it when `rx_level` is at least the depth. It is combinational from the current inputs.
- R3: `tx_irq` follows `tx_mode`: 0 asserts it when `tx_level` is 0 and `shift_busy` is low; 1 asserts it when `tx_level` is 0; 2 asserts it when the free entries (depth minus `tx_level`) are at least half the depth; 3 asserts it when `tx_level` is below the depth.
- R4: `status[20:16]` carries `tx_level` and `status[28:24]` carries `rx_level`, unchanged and with no delay.
- R5: `status[5]` is 1 exactly when `rx_level` is 0.
- R6: When `rx_word_in` arrives while `rx_level` is at least the depth, the word is dropped (`rx_wr_en` stays low) and the overflow flag `status[6]` is set from the next cycle. In every other case `rx_wr_en` equals `rx_word_in`.
- R7: Each error flag stays set until its clear strobe is pulsed. The clear strobes are `err_clr[0]` for underrun, `err_clr[1]` for overflow and `err_clr[2]` for frame error. A set and a clear in the same cycle leave the flag set.
- R8: The underrun flag `status[8]` is set when `framed` is high, `tx_word_req` is high and `tx_level` is 0. With `framed` low, the underrun condition has no effect.
- R9: While `framed` is high, an `fsync` pulse opens a frame and `frame_done` closes it. An `fsync` while a frame is open, without `frame_done` in the same cycle, sets the frame-error flag `status[12]`. Clearing `framed` closes any open frame.
- R10: `fault_irq` is high exactly when some error flag is set together with its enable bit: `err_en[0]` for underrun, `err_en[1]` for overflow, `err_en[2]` for frame error.
- R11: A cycle with `rst_n` low clears all error flags and the frame-open state. Status bits outside the fields named in R4 to R9 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| width_sel | input | 2 | Word width select (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| rx_mode | input | 2 | Receive interrupt condition select |
| tx_mode | input | 2 | Transmit interrupt condition select |
| err_en | input | 3 | Fault enables {frame, overflow, underrun} |
| err_clr | input | 3 | Flag clear strobes {frame, overflow, underrun} |
| framed | input | 1 | Framed operation enabled |
| tx_level | input | 5 | Transmit FIFO occupancy |
| rx_level | input | 5 | Receive FIFO occupancy |
| shift_busy | input | 1 | Transmit shifter holds a word in flight |
| rx_word_in | input | 1 | A received word is offered to the receive FIFO |
| tx_word_req | input | 1 | Shifter requests the next transmit word |
| fsync | input | 1 | Frame-sync pulse seen |
| frame_done | input | 1 | Current frame has ended |
| rx_wr_en | output | 1 | Receive FIFO write enable (word accepted) |
| rx_irq | output | 1 | Receive interrupt level |
| tx_irq | output | 1 | Transmit interrupt level |
| fault_irq | output | 1 | Fault interrupt level |
| status | output | 32 | Status word: levels, receive empty, sticky error flags |

## Verification
A directed sweep walks every word width and every mode over each fill level from empty to full, with the shifter both busy and idle. This separates the four threshold conditions, including the half-depth and full-depth boundaries that differ for each width, and it separates transmit mode 0 from mode 1. Short directed sequences place an overflow and its clear in the same cycle, and raise the underrun condition with framing off, to show that a set wins over a clear and that the unframed case is ignored. A long random phase mixes frame-sync pulses, frame ends, clears, enable patterns, framing toggles and occasional resets. A behavioural model follows every cycle and exposes flag timing, frame tracking and fault gating.

// File: rtl/spi_irq_pkg.sv
// Shared constants and mode encodings for the FIFO interrupt/status block.
// Assumes a 32-bit status word with fixed field positions decoded by software.
package spi_irq_pkg;

    typedef enum logic [1:0] {
        RXI_EMPTY     = 2'd0,
        RXI_NOT_EMPTY = 2'd1,
        RXI_HALF_FULL = 2'd2,
        RXI_FULL      = 2'd3
    } rx_irq_mode_e;

    typedef enum logic [1:0] {
        TXI_ALL_IDLE  = 2'd0,
        TXI_EMPTY     = 2'd1,
        TXI_HALF_FREE = 2'd2,
        TXI_ROOM      = 2'd3
    } tx_irq_mode_e;

    // Error flag indices, shared by err_en, err_clr and the flag vector
    localparam int ERR_URUN = 0;
    localparam int ERR_OVF  = 1;
    localparam int ERR_FRM  = 2;
    localparam int NUM_ERR  = 3;

    // Status bit positions (software decodes these)
    localparam int ST_RX_EMPTY = 5;
    localparam int ST_OVF      = 6;
    localparam int ST_URUN     = 8;
    localparam int ST_FRM      = 12;
    localparam int ST_TX_LVL   = 16;
    localparam int ST_RX_LVL   = 24;
    localparam int ST_LVL_W    = 5;

endpackage

// File: rtl/fifo_depth_sel.sv
// Derives the FIFO depth in entries, and half of it, from the word width.
// Assumes a byte-sized buffer shared by all widths; width codes 2 and 3 both mean 32-bit.
module fifo_depth_sel #(
    parameter int BUF_BYTES = 16,
    parameter int CNT_W     = 5
) (
    input  logic [1:0]       width_sel,
    output logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] half
);

    localparam int DEPTH8  = BUF_BYTES;
    localparam int DEPTH16 = BUF_BYTES / 2;
    localparam int DEPTH32 = BUF_BYTES / 4;

    // Pick the entry count for the selected word width
    always_comb begin
        unique case (width_sel)
            2'd0:    depth = CNT_W'(DEPTH8);
            2'd1:    depth = CNT_W'(DEPTH16);
            default: depth = CNT_W'(DEPTH32);
        endcase
        half = depth >> 1;
    end

endmodule

// File: rtl/rx_thresh.sv
// Receive interrupt condition: one of four fill conditions on the receive FIFO.
// Assumes level never exceeds depth; purely combinational.
module rx_thresh
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] half,
    output logic             irq
);

    // Evaluate the selected fill condition
    always_comb begin
        unique case (rx_irq_mode_e'(mode))
            RXI_EMPTY:     irq = (level == '0);
            RXI_NOT_EMPTY: irq = (level != '0);
            RXI_HALF_FULL: irq = (level >= half);
            RXI_FULL:      irq = (level >= depth);
            default:       irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/tx_thresh.sv
// Transmit interrupt condition: one of four space conditions on the transmit FIFO.
// Assumes level never exceeds depth; the shifter-busy input qualifies mode 0.
module tx_thresh
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] half,
    input  logic             shift_busy,
    output logic             irq
);

    logic [CNT_W-1:0] half_free_lim;

    // Highest level that still leaves at least half the entries free
    assign half_free_lim = depth - half;

    // Evaluate the selected space condition
    always_comb begin
        unique case (tx_irq_mode_e'(mode))
            TXI_ALL_IDLE:  irq = (level == '0) && !shift_busy;
            TXI_EMPTY:     irq = (level == '0);
            TXI_HALF_FREE: irq = (level <= half_free_lim);
            TXI_ROOM:      irq = (level < depth);
            default:       irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/sticky_flag.sv
// One sticky error bit: set by an event, cleared by a software strobe.
// A set in the same cycle as a clear wins, so no event is lost.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Hold the flag until cleared; a new event overrides the clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

endmodule

// File: rtl/frame_check.sv
// Tracks whether a frame is open and flags a second sync pulse inside it.
// Assumes sync and end-of-frame are single-cycle strobes; inactive while unframed.
module frame_check (
    input  logic clk,
    input  logic rst_n,
    input  logic framed,
    input  logic fsync,
    input  logic frame_done,
    output logic dup_sync
);

    logic in_frame;

    // A sync pulse while a frame is open and not ending is a duplicate
    assign dup_sync = framed && fsync && in_frame && !frame_done;

    // Frame-open state: opened by sync, closed by end or by leaving framed operation
    always_ff @(posedge clk) begin
        if (!rst_n || !framed)
            in_frame <= 1'b0;
        else if (fsync)
            in_frame <= 1'b1;
        else if (frame_done)
            in_frame <= 1'b0;
    end

endmodule

// File: rtl/fifo_irq_ctrl.sv
// FIFO threshold interrupts, sticky error flags and status word for a serial peripheral.
// Assumes the FIFO levels are registered by the FIFOs and never exceed the current depth.
// Interrupt levels are combinational; error flags are registered.
module fifo_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       width_sel,
    input  logic [1:0]       rx_mode,
    input  logic [1:0]       tx_mode,
    input  logic [2:0]       err_en,
    input  logic [2:0]       err_clr,
    input  logic             framed,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             shift_busy,
    input  logic             rx_word_in,
    input  logic             tx_word_req,
    input  logic             fsync,
    input  logic             frame_done,
    output logic             rx_wr_en,
    output logic             rx_irq,
    output logic             tx_irq,
    output logic             fault_irq,
    output logic [31:0]      status
);

    logic [CNT_W-1:0]   depth;
    logic [CNT_W-1:0]   half;
    logic               rx_full;
    logic               dup_sync;
    logic [NUM_ERR-1:0] err_set;
    logic [NUM_ERR-1:0] err_q;

    fifo_depth_sel #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_depth (
        .width_sel (width_sel),
        .depth     (depth),
        .half      (half)
    );

    rx_thresh #(.CNT_W(CNT_W)) u_rx_thresh (
        .mode  (rx_mode),
        .level (rx_level),
        .depth (depth),
        .half  (half),
        .irq   (rx_irq)
    );

    tx_thresh #(.CNT_W(CNT_W)) u_tx_thresh (
        .mode       (tx_mode),
        .level      (tx_level),
        .depth      (depth),
        .half       (half),
        .shift_busy (shift_busy),
        .irq        (tx_irq)
    );

    frame_check u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .framed     (framed),
        .fsync      (fsync),
        .frame_done (frame_done),
        .dup_sync   (dup_sync)
    );

    // Receive write gating: a word arriving at a full FIFO is dropped
    assign rx_full  = (rx_level >= depth);
    assign rx_wr_en = rx_word_in && !rx_full;

    // Error events, one per sticky flag
    always_comb begin
        err_set           = '0;
        err_set[ERR_URUN] = framed && tx_word_req && (tx_level == '0);
        err_set[ERR_OVF]  = rx_word_in && rx_full;
        err_set[ERR_FRM]  = dup_sync;
    end

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
        sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (err_set[i]),
            .clr_i  (err_clr[i]),
            .flag_o (err_q[i])
        );
    end

    // Fault line: any flag whose enable is set
    assign fault_irq = |(err_q & err_en);

    // Status word assembly; unlisted bits read zero
    always_comb begin
        status = '0;
        status[ST_TX_LVL +: CNT_W] = tx_level;
        status[ST_RX_LVL +: CNT_W] = rx_level;
        status[ST_RX_EMPTY]        = (rx_level == '0);
        status[ST_OVF]             = err_q[ERR_OVF];
        status[ST_URUN]            = err_q[ERR_URUN];
        status[ST_FRM]             = err_q[ERR_FRM];
    end

endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
// Assertion checker for fifo_irq_ctrl, attached by bind; observes ports only.
// Recomputes the depth on its own from the width select.
module fifo_irq_ctrl_chk #(
    parameter int BUF_BYTES = 16,
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       width_sel,
    input logic [1:0]       rx_mode,
    input logic [1:0]       tx_mode,
    input logic [2:0]       err_en,
    input logic [2:0]       err_clr,
    input logic             framed,
    input logic [CNT_W-1:0] tx_level,
    input logic [CNT_W-1:0] rx_level,
    input logic             rx_word_in,
    input logic             rx_wr_en,
    input logic             rx_irq,
    input logic             tx_irq,
    input logic             fault_irq,
    input logic [31:0]      status
);

    int dep;

    // Independent depth: buffer bytes divided by word bytes
    always_comb begin
        dep = (width_sel == 2'd0) ? BUF_BYTES :
              (width_sel == 2'd1) ? BUF_BYTES / 2 : BUF_BYTES / 4;
    end

    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_in && int'(rx_level) >= dep) |-> !rx_wr_en); // R6
    AST_OVF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_in && int'(rx_level) >= dep) |=> status[6]); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !err_clr[1]) |=> status[6]); // R7
    AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr[1] && !(rx_word_in && int'(rx_level) >= dep)) |=> !status[6]); // R7
    AST_URUN_UNFRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!framed && !status[8]) |=> !status[8]); // R8
    AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_en == 3'b000) |-> !fault_irq); // R10
    AST_RX_NONEMPTY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'd1) |-> (rx_irq == !status[5])); // R2
    AST_TX_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd3 && int'(tx_level) >= dep) |-> !tx_irq); // R3

endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (.*);

// File: tb/fifo_irq_ctrl_tb.sv
// Self-checking bench: behavioural reference model compared with the DUT every cycle.
module fifo_irq_ctrl_tb;

    localparam int BUF_BYTES = 16;
    localparam int CNT_W     = $clog2(BUF_BYTES + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic [1:0]       width_sel = '0;
    logic [1:0]       rx_mode = '0;
    logic [1:0]       tx_mode = '0;
    logic [2:0]       err_en = '0;
    logic [2:0]       err_clr = '0;
    logic             framed = 1'b0;
    logic [CNT_W-1:0] tx_level = '0;
    logic [CNT_W-1:0] rx_level = '0;
    logic             shift_busy = 1'b0;
    logic             rx_word_in = 1'b0;
    logic             tx_word_req = 1'b0;
    logic             fsync = 1'b0;
    logic             frame_done = 1'b0;
    logic             rx_wr_en, rx_irq, tx_irq, fault_irq;
    logic [31:0]      status;

    fifo_irq_ctrl #(.BUF_BYTES(BUF_BYTES)) u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    bit m_ovf, m_urn, m_ferr, m_open;

    function automatic int depth_of(int ws);
        if (ws == 0) return BUF_BYTES;
        if (ws == 1) return BUF_BYTES / 2;
        return BUF_BYTES / 4;
    endfunction

    function automatic bit exp_rx(int mode, int lvl, int d);
        case (mode)
            0:       return lvl == 0;
            1:       return lvl != 0;
            2:       return lvl * 2 >= d;
            default: return lvl >= d;
        endcase
    endfunction

    function automatic bit exp_tx(int mode, int lvl, int d, bit busy);
        case (mode)
            0:       return lvl == 0 && !busy;
            1:       return lvl == 0;
            2:       return (d - lvl) >= d / 2;
            default: return lvl < d;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model (called at the negative edge)
    task automatic compare_all();
        int d  = depth_of(int'(width_sel));
        int rl = int'(rx_level);
        int tl = int'(tx_level);
        chk("R1 R2 rx_irq", rx_irq, exp_rx(int'(rx_mode), rl, d));
        chk("R3 tx_irq", tx_irq, exp_tx(int'(tx_mode), tl, d, shift_busy));
        chk("R4 status levels", status & 32'h1F1F_0000, (rl << 24) | (tl << 16));
        chk("R5 rx empty bit5", status[5], rl == 0);
        chk("R6 rx_wr_en", rx_wr_en, rx_word_in && !(rl >= d));
        chk("R6 R7 overflow bit6", status[6], m_ovf);
        chk("R8 underrun bit8", status[8], m_urn);
        chk("R9 frame error bit12", status[12], m_ferr);
        chk("R11 unused status bits", status & ~32'h1F1F_1160, 32'h0);
        chk("R10 fault_irq", fault_irq,
            (m_urn && err_en[0]) || (m_ovf && err_en[1]) || (m_ferr && err_en[2]));
    endtask

    // Advance the model with the inputs the DUT sampled at this edge
    task automatic model_step();
        int d = depth_of(int'(width_sel));
        bit s_ovf, s_urn, s_frm;
        if (!rst_n) begin
            m_ovf = 0; m_urn = 0; m_ferr = 0; m_open = 0;
            return;
        end
        s_ovf = rx_word_in && int'(rx_level) >= d;
        s_urn = framed && tx_word_req && tx_level == 0;
        s_frm = framed && fsync && m_open && !frame_done;
        m_ovf  = s_ovf || (m_ovf && !err_clr[1]);
        m_urn  = s_urn || (m_urn && !err_clr[0]);
        m_ferr = s_frm || (m_ferr && !err_clr[2]);
        if (!framed)          m_open = 0;
        else if (fsync)       m_open = 1;
        else if (frame_done)  m_open = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        rx_word_in = 0; tx_word_req = 0; fsync = 0; frame_done = 0; err_clr = '0;
    endtask

    initial begin
        // Reset state (R11)
        rst_n = 1'b0;
        repeat (3) cycle();
        chk("R11 flags zero in reset", status & 32'h0000_1140, 32'h0);
        chk("R11 fault low in reset", fault_irq, 1'b0);
        rst_n = 1'b1;
        err_en = 3'b111;
        cycle();

        // Threshold sweep: every width, mode, level and shifter state (R1 R2 R3)
        for (int ws = 0; ws < 4; ws++) begin
            for (int m = 0; m < 4; m++) begin
                for (int lv = 0; lv <= depth_of(ws); lv++) begin
                    for (int b = 0; b < 2; b++) begin
                        width_sel = 2'(ws); rx_mode = 2'(m); tx_mode = 2'(3 - m);
                        rx_level = CNT_W'(lv); tx_level = CNT_W'(lv);
                        shift_busy = b[0];
                        cycle();
                        tx_mode = 2'(m);
                        cycle();
                    end
                end
            end
        end

        // Overflow with a same-cycle clear: set wins (R6 R7)
        width_sel = 2'd2; rx_level = 5'd4; rx_word_in = 1; err_clr = 3'b010;
        cycle();
        chk("R7 set beats clear", status[6], 1'b1);
        quiet(); cycle();
        err_clr = 3'b010; cycle();
        chk("R7 clear strobe", status[6], 1'b0);
        quiet();

        // Underrun condition with framing off is ignored (R8)
        framed = 0; tx_level = '0; tx_word_req = 1; cycle(); cycle();
        chk("R8 unframed underrun ignored", status[8], 1'b0);
        framed = 1; cycle();
        chk("R8 framed underrun sets", status[8], 1'b1);
        quiet();

        // Duplicate sync inside a frame (R9)
        err_clr = 3'b111; cycle(); quiet();
        fsync = 1; cycle();
        fsync = 1; cycle();
        chk("R9 duplicate sync", status[12], 1'b1);
        quiet(); err_en = 3'b011; cycle();
        chk("R10 frame error masked", fault_irq, status[8] | status[6]);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int d;
            rst_n       = ($urandom_range(0, 299) != 0);
            width_sel   = 2'($urandom_range(0, 3));
            d           = depth_of(int'(width_sel));
            rx_mode     = 2'($urandom_range(0, 3));
            tx_mode     = 2'($urandom_range(0, 3));
            err_en      = 3'($urandom_range(0, 7));
            err_clr     = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                           ($urandom_range(0, 7) == 0)};
            if ($urandom_range(0, 49) == 0) framed = ~framed;
            rx_level    = CNT_W'($urandom_range(0, d));
            tx_level    = ($urandom_range(0, 3) == 0) ? '0 : CNT_W'($urandom_range(0, d));
            shift_busy  = $urandom_range(0, 1) != 0;
            rx_word_in  = $urandom_range(0, 1) != 0;
            tx_word_req = $urandom_range(0, 3) == 0;
            fsync       = $urandom_range(0, 3) == 0;
            frame_done  = $urandom_range(0, 3) == 0;
            cycle();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule